// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit sits between a register bus and the serial shift engine of one SPI channel. It holds two word queues: a transmit queue that software fills and the engine drains, and a receive queue that the engine fills and software drains. It also holds the registers that describe them: a status register, an interrupt-enable register, a threshold register and a packed occupancy readout.

Events from the queues and the engine are latched into sticky status bits. The events are transfer done, transmit level reached, receive level reached, transmit starved and receive overrun. Software clears a status bit by writing a one to it. A single interrupt line is raised while any latched event has its enable set. The engine's busy indication is shown live in the status word and never interrupts.

Registers are selected by a word index on `regAddr`: 0 status, 1 interrupt enable, 2 threshold, 3 occupancy, 4 transmit data (write), 5 receive data (read). Read data is combinational from the current state. Queue pushes and pops take effect at the clock edge that ends the access.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset both queues are empty, interrupt enable reads 0, threshold reads 0x80 and `irqOut` is low. From the first clock after reset, status reads 0x04, because the empty transmit queue meets its level of 0.
- R2: Each queue holds 8 words and delivers them first in, first out. Writes to index 4 appear in order on `engTxData` as the engine pops them. Words pushed by the engine are returned in order by reads of index 5.
- R3: Index 3 reads receive occupancy in bits 3:0 and transmit occupancy in bits 7:4, with all higher bits zero.
- R4: A write to index 4 while the transmit queue holds 8 words is dropped. The occupancy stays 8 and the queued words are unchanged.
- R5: A read of index 5 while the receive queue is empty returns 0 and leaves the occupancy at 0.
- R6: Status bit 1 (done) is set on the clock edge where `engDone` is high. It stays set until software clears it.
- R7: Status bit 0 follows `engBusy` in the same cycle. Writing it has no effect.
- R8: A write to index 0 clears exactly the status bits 5:1 that are one in the write data. If a set event occurs in the same cycle, the bit stays set.
- R9: Status bit 2 sets while transmit occupancy is at or below threshold bits 3:0. Status bit 3 sets while receive occupancy is at or above threshold bits 7:4.
- R10: Status bit 4 sets when the engine pops an empty transmit queue, and `engTxData` then reads 0. Status bit 5 sets when the engine pushes into a full receive queue, and that word is dropped.
- R11: `irqOut` is high while any status bit k+1 (k = 0..4) is set with interrupt-enable bit k set. Enable bit 0 is done, 1 transmit level, 2 receive level, 3 transmit starve, 4 receive overrun. Status bit 0 never interrupts.
- R12: Interrupt enable reads back its 5 written bits, and threshold reads back its 8 written bits. All higher bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register word index |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdEn | input | 1 | Register read strobe (pops the receive queue at index 5) |
| regRdData | output | 32 | Register read data, combinational |
| engTxPop | input | 1 | Engine takes the transmit head word |
| engTxData | output | 32 | Transmit head word, 0 when empty |
| engRxPush | input | 1 | Engine delivers a received word |
| engRxData | input | 32 | Received word from the engine |
| engBusy | input | 1 | Engine transfer in progress |
| engDone | input | 1 | One-cycle transfer-complete pulse |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest situations to reach from the ports are the ones where a set event and a software clear of the same status bit fall in the same cycle. The level-driven threshold bits are the main case, since they reassert on every edge while their condition holds.

The stimulus reaches these cases through the threshold register. It programs levels, fills or drains the queues until occupancy sits just across a level, clears the bit, and then moves occupancy by one word. It also clears the transmit-level bit while the queue is empty so that the set-wins rule is observed.

Overflow and underflow are reached by filling the receive queue to 8 from the engine side and by popping an empty transmit queue.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT = 3'd0,
    REG_IEN  = 3'd1,
    REG_THR  = 3'd2,
    REG_CNT  = 3'd3,
    REG_TXD  = 3'd4,
    REG_RXD  = 3'd5
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic engTxPop;
    logic engRxPush;
  } fifoStrobe_t;

  localparam int ST_PEND = 0;
  localparam int ST_DONE = 1;
  localparam int ST_TXTH = 2;
  localparam int ST_RXTH = 3;
  localparam int ST_TXUF = 4;
  localparam int ST_RXOF = 5;
  localparam int IEN_W   = 5;
endpackage

// File: rtl/sfu_word_fifo.sv
module sfu_word_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [DW-1:0]    pushData,
  input  logic             popEn,
  output logic [DW-1:0]    headData,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             isFull, isEmpty, pushOk, popOk;

  assign isFull  = (count == FULL_CNT);
  assign isEmpty = (count == '0);
  assign pushOk  = pushEn && !isFull;
  assign popOk   = popEn && !isEmpty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R4
  full_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && isFull && !popEn) |=> $stable(count));

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && isEmpty && !pushEn) |=> (count == '0));
endmodule

// File: rtl/sfu_datapath.sv
module sfu_datapath
  import sfu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strb,
  input  logic [DW-1:0]    txWrData,
  input  logic [DW-1:0]    rxInData,
  output logic [DW-1:0]    engTxData,
  output logic [DW-1:0]    rxHead,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic             txEmpty,
  output logic             rxFull
);
  logic [DW-1:0] txHead;
  logic [DW-1:0] rxHeadRaw;

  sfu_word_fifo #(.DW(DW), .DEPTH(DEPTH)) i_txFifo (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (strb.txPush),
    .pushData (txWrData),
    .popEn    (strb.engTxPop),
    .headData (txHead),
    .count    (txCount)
  );

  sfu_word_fifo #(.DW(DW), .DEPTH(DEPTH)) i_rxFifo (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (strb.engRxPush),
    .pushData (rxInData),
    .popEn    (strb.rxPop),
    .headData (rxHeadRaw),
    .count    (rxCount)
  );

  assign txEmpty   = (txCount == '0);
  assign rxFull    = (rxCount == CNT_W'(DEPTH));
  assign engTxData = txEmpty ? '0 : txHead;
  assign rxHead    = (rxCount == '0) ? '0 : rxHeadRaw;
endmodule

// File: rtl/sfu_control.sv
module sfu_control
  import sfu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int WB_W  = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WB_W-1:0]   wrByte,
  input  logic              regRdEn,
  output logic [DW-1:0]     regRdData,
  input  logic              engTxPop,
  input  logic              engRxPush,
  input  logic              engBusy,
  input  logic              engDone,
  input  logic [DW-1:0]     rxHead,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              txEmpty,
  input  logic              rxFull,
  output fifoStrobe_t       strb,
  output logic              irqOut
);
  logic [ST_RXOF:ST_DONE] stickyQ, stickyD, setVec, clrVec;
  logic [IEN_W-1:0]       intEnQ;
  logic [CNT_W-1:0]       txLevelQ, rxLevelQ;
  logic                   wrStat, wrIen, wrThr;

  assign wrStat = regWrEn && (regAddr == REG_STAT);
  assign wrIen  = regWrEn && (regAddr == REG_IEN);
  assign wrThr  = regWrEn && (regAddr == REG_THR);

  always_comb begin
    strb           = '0;
    strb.txPush    = regWrEn && (regAddr == REG_TXD);
    strb.rxPop     = regRdEn && (regAddr == REG_RXD);
    strb.engTxPop  = engTxPop;
    strb.engRxPush = engRxPush;
  end

  always_comb begin
    setVec          = '0;
    setVec[ST_DONE] = engDone;
    setVec[ST_TXTH] = (txCount <= txLevelQ);
    setVec[ST_RXTH] = (rxCount >= rxLevelQ);
    setVec[ST_TXUF] = engTxPop && txEmpty;
    setVec[ST_RXOF] = engRxPush && rxFull;
    clrVec  = wrStat ? wrByte[ST_RXOF:ST_DONE] : '0;
    stickyD = (stickyQ & ~clrVec) | setVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stickyQ  <= '0;
      intEnQ   <= '0;
      txLevelQ <= '0;
      rxLevelQ <= CNT_W'(DEPTH);
    end else begin
      stickyQ <= stickyD;
      if (wrIen) intEnQ <= wrByte[IEN_W-1:0];
      if (wrThr) begin
        txLevelQ <= wrByte[CNT_W-1:0];
        rxLevelQ <= wrByte[WB_W-1:CNT_W];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_STAT: begin
        regRdData[ST_PEND]         = engBusy;
        regRdData[ST_RXOF:ST_DONE] = stickyQ;
      end
      REG_IEN: regRdData[IEN_W-1:0] = intEnQ;
      REG_THR: begin
        regRdData[CNT_W-1:0]    = txLevelQ;
        regRdData[WB_W-1:CNT_W] = rxLevelQ;
      end
      REG_CNT: begin
        regRdData[CNT_W-1:0]    = rxCount;
        regRdData[WB_W-1:CNT_W] = txCount;
      end
      REG_RXD: regRdData = rxHead;
      default: regRdData = '0;
    endcase
  end

  assign irqOut = |(stickyQ & intEnQ);

  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    engDone |=> stickyQ[ST_DONE]);

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && wrByte[ST_DONE] && !engDone) |=> !stickyQ[ST_DONE]);

  // R10
  overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && rxFull) |=> stickyQ[ST_RXOF]);

  // R10
  underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engTxPop && txEmpty) |=> stickyQ[ST_TXUF]);

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intEnQ == '0) |-> !irqOut);
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import sfu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DW-1:0]     regWrData,
  input  logic              regRdEn,
  output logic [DW-1:0]     regRdData,
  input  logic              engTxPop,
  output logic [DW-1:0]     engTxData,
  input  logic              engRxPush,
  input  logic [DW-1:0]     engRxData,
  input  logic              engBusy,
  input  logic              engDone,
  output logic              irqOut
);
  fifoStrobe_t      strb;
  logic [DW-1:0]    rxHead;
  logic [CNT_W-1:0] txCount, rxCount;
  logic             txEmpty, rxFull;

  sfu_control #(.DW(DW), .DEPTH(DEPTH)) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .wrByte    (regWrData[2*CNT_W-1:0]),
    .regRdEn   (regRdEn),
    .regRdData (regRdData),
    .engTxPop  (engTxPop),
    .engRxPush (engRxPush),
    .engBusy   (engBusy),
    .engDone   (engDone),
    .rxHead    (rxHead),
    .txCount   (txCount),
    .rxCount   (rxCount),
    .txEmpty   (txEmpty),
    .rxFull    (rxFull),
    .strb      (strb),
    .irqOut    (irqOut)
  );

  sfu_datapath #(.DW(DW), .DEPTH(DEPTH)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .txWrData  (regWrData),
    .rxInData  (engRxData),
    .engTxData (engTxData),
    .rxHead    (rxHead),
    .txCount   (txCount),
    .rxCount   (rxCount),
    .txEmpty   (txEmpty),
    .rxFull    (rxFull)
  );
endmodule

// File: tb/test_spi_fifo_irq_unit.sv
module test_spi_fifo_irq_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic        engTxPop = 1'b0;
  logic [31:0] engTxData;
  logic        engRxPush = 1'b0;
  logic [31:0] engRxData = '0;
  logic        engBusy = 1'b0;
  logic        engDone = 1'b0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_fifo_irq_unit i_spi_fifo_irq_unit (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .engTxPop(engTxPop), .engTxData(engTxData), .engRxPush(engRxPush),
    .engRxData(engRxData), .engBusy(engBusy), .engDone(engDone),
    .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    #2 d = regRdData;
    @(posedge clk); @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic engPop(output logic [31:0] d);
    #2 d = engTxData;
    engTxPop = 1'b1;
    @(posedge clk); @(negedge clk);
    engTxPop = 1'b0;
  endtask

  task automatic engPush(input logic [31:0] d);
    engRxData = d; engRxPush = 1'b1;
    @(posedge clk); @(negedge clk);
    engRxPush = 1'b0;
  endtask

  task automatic pulseDone();
    engDone = 1'b1;
    @(posedge clk); @(negedge clk);
    engDone = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    busRead(3'd0, d); check(d == 32'h4, "R1 status", d, 32'h4);
    busRead(3'd3, d); check(d == 0, "R1 count", d, 0);
    busRead(3'd1, d); check(d == 0, "R1 ien", d, 0);
    busRead(3'd2, d); check(d == 32'h80, "R1 thr", d, 32'h80);
    check(irqOut == 1'b0, "R1 irq", {31'b0, irqOut}, 0);
  endtask

  task automatic t_txOrder();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) busWrite(3'd4, 32'hA000_0000 + i);
    busRead(3'd3, d); check(d == 32'h80, "R3 tx full count", d, 32'h80);
    busWrite(3'd4, 32'hBAD0_0000);
    busRead(3'd3, d); check(d == 32'h80, "R4 push to full", d, 32'h80);
    for (int i = 0; i < 8; i++) begin
      engPop(d);
      check(d == 32'hA000_0000 + i, "R2 tx order", d, 32'hA000_0000 + i);
    end
    busRead(3'd3, d); check(d == 0, "R4 no extra word", d, 0);
  endtask

  task automatic t_rxOrder();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) engPush(32'hC0DE_0000 + i);
    busRead(3'd3, d); check(d == 32'h03, "R3 rx count", d, 32'h03);
    for (int i = 0; i < 3; i++) begin
      busRead(3'd5, d);
      check(d == 32'hC0DE_0000 + i, "R2 rx order", d, 32'hC0DE_0000 + i);
    end
    busRead(3'd5, d); check(d == 0, "R5 empty pop data", d, 0);
    busRead(3'd3, d); check(d == 0, "R5 empty pop count", d, 0);
  endtask

  task automatic t_countPack();
    logic [31:0] d;
    busWrite(3'd4, 32'h1); busWrite(3'd4, 32'h2);
    for (int i = 0; i < 5; i++) engPush(i);
    busRead(3'd3, d); check(d == 32'h25, "R3 packed count", d, 32'h25);
    engPop(d); engPop(d);
    for (int i = 0; i < 5; i++) busRead(3'd5, d);
    busRead(3'd3, d); check(d == 0, "R3 drained", d, 0);
  endtask

  task automatic t_done();
    logic [31:0] d;
    busWrite(3'd0, 32'h3F);
    busRead(3'd0, d); check((d & 32'h2) == 0, "R6 done clear", d, 0);
    pulseDone();
    busRead(3'd0, d); check((d & 32'h2) != 0, "R6 done set", d, 32'h2);
    repeat (3) @(negedge clk);
    busRead(3'd0, d); check((d & 32'h2) != 0, "R6 done sticky", d, 32'h2);
    busWrite(3'd0, 32'h10);
    busRead(3'd0, d); check((d & 32'h2) != 0, "R8 other bit untouched", d, 32'h2);
    busWrite(3'd0, 32'h2);
    busRead(3'd0, d); check((d & 32'h2) == 0, "R8 w1c done", d, 0);
    busWrite(3'd0, 32'h4);
    busRead(3'd0, d); check((d & 32'h4) != 0, "R8 set wins", d, 32'h4);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    engBusy = 1'b1;
    busRead(3'd0, d); check((d & 32'h1) != 0, "R7 pending high", d, 1);
    busWrite(3'd0, 32'h1);
    busRead(3'd0, d); check((d & 32'h1) != 0, "R7 pending unclearable", d, 1);
    engBusy = 1'b0;
    busRead(3'd0, d); check((d & 32'h1) == 0, "R7 pending low", d, 0);
  endtask

  task automatic t_thresh();
    logic [31:0] d;
    busWrite(3'd2, 32'h32);
    for (int i = 0; i < 3; i++) busWrite(3'd4, i);
    busWrite(3'd0, 32'h0C);
    repeat (2) @(negedge clk);
    busRead(3'd0, d); check((d & 32'hC) == 0, "R9 above/below level", d, 0);
    engPop(d);
    repeat (2) @(negedge clk);
    busRead(3'd0, d); check((d & 32'h4) != 0, "R9 tx level reached", d, 32'h4);
    engPush(1); engPush(2);
    busWrite(3'd0, 32'h08);
    repeat (2) @(negedge clk);
    busRead(3'd0, d); check((d & 32'h8) == 0, "R9 rx below level", d, 0);
    engPush(3);
    repeat (2) @(negedge clk);
    busRead(3'd0, d); check((d & 32'h8) != 0, "R9 rx level reached", d, 32'h8);
    engPop(d); engPop(d);
    for (int i = 0; i < 3; i++) busRead(3'd5, d);
    busWrite(3'd2, 32'h80);
  endtask

  task automatic t_errors();
    logic [31:0] d;
    busWrite(3'd0, 32'h3F);
    engPop(d); check(d == 0, "R10 empty pop data", d, 0);
    busRead(3'd0, d); check((d & 32'h10) != 0, "R10 underflow", d, 32'h10);
    for (int i = 0; i < 8; i++) engPush(32'h5500 + i);
    busRead(3'd0, d); check((d & 32'h20) == 0, "R10 no overflow yet", d, 0);
    engPush(32'hDEAD);
    busRead(3'd0, d); check((d & 32'h20) != 0, "R10 overflow", d, 32'h20);
    for (int i = 0; i < 8; i++) begin
      busRead(3'd5, d);
      check(d == 32'h5500 + i, "R10 dropped word", d, 32'h5500 + i);
    end
  endtask

  task automatic t_irq();
    logic [31:0] d;
    busWrite(3'd0, 32'h3F);
    busWrite(3'd1, 32'h0);
    check(irqOut == 1'b0, "R11 masked", {31'b0, irqOut}, 0);
    busWrite(3'd1, 32'h2);
    check(irqOut == 1'b1, "R11 tx level irq", {31'b0, irqOut}, 1);
    busWrite(3'd1, 32'h1);
    check(irqOut == 1'b0, "R11 done not set", {31'b0, irqOut}, 0);
    engBusy = 1'b1;
    @(negedge clk);
    check(irqOut == 1'b0, "R11 pending no irq", {31'b0, irqOut}, 0);
    engBusy = 1'b0;
    pulseDone();
    check(irqOut == 1'b1, "R11 done irq", {31'b0, irqOut}, 1);
    busWrite(3'd0, 32'h2);
    check(irqOut == 1'b0, "R11 irq cleared", {31'b0, irqOut}, 0);
    busWrite(3'd1, 32'hFFFF_FFFF);
    busRead(3'd1, d); check(d == 32'h1F, "R12 ien readback", d, 32'h1F);
    busWrite(3'd2, 32'hFFFF_FFFF);
    busRead(3'd2, d); check(d == 32'hFF, "R12 thr readback", d, 32'hFF);
    busWrite(3'd1, 32'h0);
    busWrite(3'd2, 32'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_txOrder();
    t_rxOrder();
    t_countPack();
    t_done();
    t_pending();
    t_thresh();
    t_errors();
    t_irq();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule